// File: doc/BRIEF.md
# Cache Range Maintenance Sequencer

This block turns one cache maintenance request into a stream of commands for an outer cache controller. A request names an operation (invalidate, clean or flush) and a byte range given by a start address and an exclusive end address. The block aligns the range to cache lines and gives the partial edge lines of an invalidate a line-level clean-and-invalidate, so that dirty data sharing those lines is not lost. It then cuts the full-line part into chunks. A chunk never exceeds a fixed byte budget and never crosses a page boundary.

Each chunk leaves as a range command that carries the inclusive address of its first line and of its last line. Every command is offered on a valid/ready handshake and is held until it is taken. A one-cycle done pulse follows acceptance of the last command. A write-through override, sampled with the request, drops all clean work: a clean request issues nothing, and a flush request issues only invalidate ranges.

Top module: `cache_range_seq`

## Requirements
- R1: After reset the block is idle: `req_ready` is 1, and `cmd_valid` and `done` are 0. A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` stays 0 from that edge until the cycle after the done pulse, and `req_valid` has no effect while `req_ready` is 0.
- R2: Lines are 32 bytes. `cmd_kind` is 0 for a single-line clean-and-invalidate, 1 for a clean range and 2 for an invalidate range. `cmd_lo` and `cmd_hi` are line-aligned. A range covers every line from `cmd_lo` to `cmd_hi` inclusive, with `cmd_hi` ≥ `cmd_lo`. A single-line command has `cmd_lo` equal to `cmd_hi`, both set to that line's address.
- R3: One range command covers at most 1024 bytes, so `cmd_hi - cmd_lo` ≤ 992.
- R4: Pages are 4096 bytes. A range command never crosses a page boundary, and each chunk ends at the earliest of three points: the range end, the chunk start plus 1024, and the next page boundary above the chunk start.
- R5: `req_op` 0 is invalidate. If its start is not line-aligned, a single-line command on the containing line comes first, and the range start moves to the next line boundary.
- R6: For an invalidate, if the advanced start is still below the end and the end is not line-aligned, a single-line command on the end's line follows. The end is then rounded down, and only after that are invalidate range commands issued.
- R7: `req_op` 1 is clean and `req_op` 2 is flush. For both, the start is rounded down and the end rounded up to line boundaries before chunking. Clean issues clean range commands.
- R8: A flush without override issues, for each chunk, a clean range and then an invalidate range with the same bounds, before moving to the next chunk.
- R9: With `req_wt_override` 1 at acceptance, a clean issues no commands and a flush issues only the invalidate range of each chunk.
- R10: While `cmd_valid` is 1 and `cmd_ready` is 0, `cmd_valid`, `cmd_kind`, `cmd_lo` and `cmd_hi` keep their values into the next cycle.
- R11: `done` is 1 for exactly one cycle, the cycle after the edge that takes the final command, and is 0 the cycle after.
- R12: A request whose aligned range is empty, or whose `req_op` is 3, issues no commands, and `done` pulses in the cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| req_op | input | 2 | 0 invalidate, 1 clean, 2 flush, 3 no-op |
| req_start | input | 32 | First byte of the range |
| req_end | input | 32 | Byte after the last byte of the range |
| req_wt_override | input | 1 | Write-through override, sampled with the request |
| cmd_valid | output | 1 | Command offered |
| cmd_ready | input | 1 | Controller takes the command |
| cmd_kind | output | 2 | 0 line clean-and-invalidate, 1 clean range, 2 invalidate range |
| cmd_lo | output | 32 | First line address (inclusive) |
| cmd_hi | output | 32 | Last line address (inclusive) |
| done | output | 1 | One-cycle completion pulse |

## Verification
Two things can meet in one cycle: a command handshake in the middle of a stream, and a new request arriving on `req_valid`. The bench provokes this by raising a foreign invalidate request for one cycle while a long flush is still emitting commands under a randomly throttled `cmd_ready`. The scoreboard then requires the stream to match exactly the flush's expected commands, with no trace of the foreign request. A second overlap is the clean-range handshake of a flush chunk and the switch to that chunk's invalidate. It is judged by demanding the invalidate, with identical bounds, as the very next command popped from the queue.

// File: rtl/crs_pkg.sv
package crs_pkg;

   typedef enum logic [1:0] {
      OP_INV   = 2'd0,
      OP_CLEAN = 2'd1,
      OP_FLUSH = 2'd2,
      OP_NONE  = 2'd3
   } crs_op_e;

   typedef enum logic [1:0] {
      CMD_LINE_CI   = 2'd0,
      CMD_CLEAN_RNG = 2'd1,
      CMD_INV_RNG   = 2'd2,
      CMD_RSVD      = 2'd3
   } crs_cmd_e;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_HEAD  = 3'd1,
      ST_TAIL  = 3'd2,
      ST_CLEAN = 3'd3,
      ST_INV   = 3'd4,
      ST_DONE  = 3'd5
   } crs_state_e;

endpackage

// File: rtl/crs_req_align.sv
module crs_req_align
   import crs_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int LINE_BYTES = 32
) (
   input  crs_op_e             op,
   input  logic                wt,
   input  logic [ADDR_W-1:0]   start_a,
   input  logic [ADDR_W-1:0]   end_a,
   output logic                head_pend,
   output logic [ADDR_W-1:0]   head_addr,
   output logic                tail_pend,
   output logic [ADDR_W-1:0]   tail_addr,
   output logic [ADDR_W-1:0]   cur,
   output logic [ADDR_W-1:0]   lim
);
   localparam int              LINE_SH = $clog2(LINE_BYTES);
   localparam logic [ADDR_W-1:0] LINE_A = ADDR_W'(LINE_BYTES);
   localparam logic [ADDR_W-1:0] LMASK  = LINE_A - 1'b1;

   logic [ADDR_W-1:0] s_dn, e_dn, s_up, e_up;
   logic              s_mis, e_mis;

   always_comb begin
      s_dn  = start_a & ~LMASK;
      e_dn  = end_a & ~LMASK;
      s_mis = |start_a[LINE_SH-1:0];
      e_mis = |end_a[LINE_SH-1:0];
      s_up  = s_mis ? s_dn + LINE_A : s_dn;
      e_up  = e_mis ? e_dn + LINE_A : e_dn;

      head_pend = 1'b0;
      head_addr = s_dn;
      tail_pend = 1'b0;
      tail_addr = e_dn;
      cur       = '0;
      lim       = '0;

      unique case (op)
         OP_INV: begin
            head_pend = s_mis;
            cur       = s_up;
            tail_pend = (s_up < end_a) && e_mis;
            lim       = tail_pend ? e_dn : end_a;
         end
         OP_CLEAN: begin
            cur = s_dn;
            lim = wt ? s_dn : e_up;
         end
         OP_FLUSH: begin
            cur = s_dn;
            lim = e_up;
         end
         default: begin
            cur = '0;
            lim = '0;
         end
      endcase
   end

endmodule

// File: rtl/crs_chunk_calc.sv
module crs_chunk_calc #(
   parameter int ADDR_W          = 32,
   parameter int LINE_BYTES      = 32,
   parameter int PAGE_BYTES      = 4096,
   parameter int MAX_CHUNK_BYTES = 1024
) (
   input  logic [ADDR_W-1:0] cur,
   input  logic [ADDR_W-1:0] lim,
   output logic [ADDR_W-1:0] chunk_end,
   output logic [ADDR_W-1:0] chunk_last
);
   localparam logic [ADDR_W:0]   MAX_W  = (ADDR_W+1)'(MAX_CHUNK_BYTES);
   localparam logic [ADDR_W:0]   PAGE_W = (ADDR_W+1)'(PAGE_BYTES);
   localparam logic [ADDR_W-1:0] PMASK  = ADDR_W'(PAGE_BYTES) - 1'b1;
   localparam logic [ADDR_W-1:0] LINE_A = ADDR_W'(LINE_BYTES);

   logic [ADDR_W:0] page_end, cap;

   assign page_end = {1'b0, cur & ~PMASK} + PAGE_W;

   generate
      if (MAX_CHUNK_BYTES >= PAGE_BYTES) begin : g_page_only
         assign cap = page_end;
      end else begin : g_size_and_page
         logic [ADDR_W:0] size_end;
         assign size_end = {1'b0, cur} + MAX_W;
         assign cap      = (size_end < page_end) ? size_end : page_end;
      end
   endgenerate

   assign chunk_end  = ({1'b0, lim} < cap) ? lim : cap[ADDR_W-1:0];
   assign chunk_last = chunk_end - LINE_A;

endmodule

// File: rtl/cache_range_seq.sv
module cache_range_seq
   import crs_pkg::*;
#(
   parameter int ADDR_W          = 32,
   parameter int LINE_BYTES      = 32,
   parameter int PAGE_BYTES      = 4096,
   parameter int MAX_CHUNK_BYTES = 1024
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [1:0]        req_op,
   input  logic [ADDR_W-1:0] req_start,
   input  logic [ADDR_W-1:0] req_end,
   input  logic              req_wt_override,
   output logic              cmd_valid,
   input  logic              cmd_ready,
   output logic [1:0]        cmd_kind,
   output logic [ADDR_W-1:0] cmd_lo,
   output logic [ADDR_W-1:0] cmd_hi,
   output logic              done
);
   localparam int LINE_SH = $clog2(LINE_BYTES);
   localparam int PAGE_SH = $clog2(PAGE_BYTES);

   initial begin
      line_pow2_chk: assert ((1 << LINE_SH) == LINE_BYTES)
         else $error("line size must be a power of two");
      page_pow2_chk: assert ((1 << PAGE_SH) == PAGE_BYTES && PAGE_BYTES >= LINE_BYTES)
         else $error("page size must be a power of two no smaller than a line");
      chunk_size_chk: assert (MAX_CHUNK_BYTES >= LINE_BYTES && MAX_CHUNK_BYTES % LINE_BYTES == 0)
         else $error("chunk budget must be a whole number of lines");
   end

   crs_state_e        state_q;
   crs_op_e           op_q;
   logic              wt_q, tail_pend_q;
   logic [ADDR_W-1:0] head_addr_q, tail_addr_q, cur_q, lim_q;

   logic              a_head, a_tail;
   logic [ADDR_W-1:0] a_head_addr, a_tail_addr, a_cur, a_lim;
   logic [ADDR_W-1:0] chunk_end, chunk_last;
   logic              take_req, take_cmd;

   crs_req_align #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) align_i (
      .op        (crs_op_e'(req_op)),
      .wt        (req_wt_override),
      .start_a   (req_start),
      .end_a     (req_end),
      .head_pend (a_head),
      .head_addr (a_head_addr),
      .tail_pend (a_tail),
      .tail_addr (a_tail_addr),
      .cur       (a_cur),
      .lim       (a_lim)
   );

   crs_chunk_calc #(
      .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES),
      .PAGE_BYTES(PAGE_BYTES), .MAX_CHUNK_BYTES(MAX_CHUNK_BYTES)
   ) chunk_i (
      .cur        (cur_q),
      .lim        (lim_q),
      .chunk_end  (chunk_end),
      .chunk_last (chunk_last)
   );

   function automatic crs_state_e chunk_state(input crs_op_e op, input logic wt,
                                              input logic [ADDR_W-1:0] c,
                                              input logic [ADDR_W-1:0] l);
      if (c >= l)                                        return ST_DONE;
      if (op == OP_CLEAN || (op == OP_FLUSH && !wt))     return ST_CLEAN;
      return ST_INV;
   endfunction

   assign req_ready = (state_q == ST_IDLE);
   assign done      = (state_q == ST_DONE);
   assign cmd_valid = (state_q == ST_HEAD) || (state_q == ST_TAIL) ||
                      (state_q == ST_CLEAN) || (state_q == ST_INV);
   assign take_req  = req_valid && req_ready;
   assign take_cmd  = cmd_valid && cmd_ready;

   always_comb begin
      cmd_kind = CMD_LINE_CI;
      cmd_lo   = cur_q;
      cmd_hi   = chunk_last;
      unique case (state_q)
         ST_HEAD:  begin cmd_lo = head_addr_q; cmd_hi = head_addr_q; end
         ST_TAIL:  begin cmd_lo = tail_addr_q; cmd_hi = tail_addr_q; end
         ST_CLEAN: cmd_kind = CMD_CLEAN_RNG;
         ST_INV:   cmd_kind = CMD_INV_RNG;
         default:  ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         op_q        <= OP_NONE;
         wt_q        <= 1'b0;
         tail_pend_q <= 1'b0;
         head_addr_q <= '0;
         tail_addr_q <= '0;
         cur_q       <= '0;
         lim_q       <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: if (take_req) begin
               op_q        <= crs_op_e'(req_op);
               wt_q        <= req_wt_override;
               tail_pend_q <= a_tail;
               head_addr_q <= a_head_addr;
               tail_addr_q <= a_tail_addr;
               cur_q       <= a_cur;
               lim_q       <= a_lim;
               if (a_head)      state_q <= ST_HEAD;
               else if (a_tail) state_q <= ST_TAIL;
               else state_q <= chunk_state(crs_op_e'(req_op), req_wt_override, a_cur, a_lim);
            end
            ST_HEAD: if (take_cmd) begin
               if (tail_pend_q) state_q <= ST_TAIL;
               else             state_q <= chunk_state(op_q, wt_q, cur_q, lim_q);
            end
            ST_TAIL: if (take_cmd)
               state_q <= chunk_state(op_q, wt_q, cur_q, lim_q);
            ST_CLEAN: if (take_cmd) begin
               if (op_q == OP_FLUSH) state_q <= ST_INV;
               else begin
                  cur_q   <= chunk_end;
                  state_q <= chunk_state(op_q, wt_q, chunk_end, lim_q);
               end
            end
            ST_INV: if (take_cmd) begin
               cur_q   <= chunk_end;
               state_q <= chunk_state(op_q, wt_q, chunk_end, lim_q);
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !cmd_valid);

   // R2
   line_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> (cmd_lo[LINE_SH-1:0] == '0) && (cmd_hi[LINE_SH-1:0] == '0) && (cmd_hi >= cmd_lo));

   // R3
   span_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_kind != CMD_LINE_CI) |->
         ((cmd_hi - cmd_lo) <= ADDR_W'(MAX_CHUNK_BYTES - LINE_BYTES)));

   // R4
   one_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> (cmd_lo[ADDR_W-1:PAGE_SH] == cmd_hi[ADDR_W-1:PAGE_SH]));

   // R8
   flush_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take_cmd && cmd_kind == CMD_CLEAN_RNG && op_q == OP_FLUSH) |=>
         (cmd_valid && cmd_kind == CMD_INV_RNG && $stable(cmd_lo) && $stable(cmd_hi)));

   // R9
   wt_no_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && wt_q) |-> (cmd_kind != CMD_CLEAN_RNG));

   // R10
   cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !cmd_ready) |=>
         (cmd_valid && $stable(cmd_kind) && $stable(cmd_lo) && $stable(cmd_hi)));

   // R11
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && req_ready));

endmodule

// File: tb/cache_range_seq_tb_top.sv
module cache_range_seq_tb_top;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [1:0]  req_op = 2'd0;
   logic [31:0] req_start = '0;
   logic [31:0] req_end = '0;
   logic        req_wt_override = 1'b0;
   logic        cmd_valid;
   logic        cmd_ready = 1'b0;
   logic [1:0]  cmd_kind;
   logic [31:0] cmd_lo, cmd_hi;
   logic        done;

   always #(CLK_PERIOD/2) clk = ~clk;

   cache_range_seq dut_i (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
      .req_start(req_start), .req_end(req_end), .req_wt_override(req_wt_override),
      .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_kind(cmd_kind),
      .cmd_lo(cmd_lo), .cmd_hi(cmd_hi), .done(done)
   );

   typedef struct packed {
      logic [1:0]  kind;
      logic [31:0] lo;
      logic [31:0] hi;
   } item_t;

   item_t       exp_q[$];
   int          n_cmp = 0;
   int          n_bad = 0;
   int          done_seen = 0;
   string       cur_tag = "R1";
   logic [15:0] lfsr = 16'hACE1;
   bit          rdy_always = 1'b1;
   bit          prev_wait = 1'b0;
   bit          prev_done = 1'b0;
   item_t       prev_item;

   task automatic check(input bit ok, input string tag, input string what,
                        input logic [97:0] act, input logic [97:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic push(input logic [1:0] k, input logic [32:0] lo, input logic [32:0] hi);
      item_t it;
      it.kind = k; it.lo = lo[31:0]; it.hi = hi[31:0];
      exp_q.push_back(it);
   endtask

   task automatic push_chunks(input logic [32:0] s_in, input logic [32:0] e, input bit cl, input bit inv);
      logic [32:0] s, ce, pe;
      s = s_in;
      while (s < e) begin
         ce = e;
         if (ce > s + 33'd1024) ce = s + 33'd1024;
         pe = (s | 33'hFFF) + 33'd1;
         if (ce > pe) ce = pe;
         if (cl)  push(2'd1, s, ce - 33'd32);
         if (inv) push(2'd2, s, ce - 33'd32);
         s = ce;
      end
   endtask

   task automatic build(input logic [1:0] op, input logic [31:0] s_in, input logic [31:0] e_in, input bit wt);
      logic [32:0] s, e;
      s = {1'b0, s_in}; e = {1'b0, e_in};
      case (op)
         2'd0: begin
            if (s[4:0] != 0) begin
               push(2'd0, s & ~33'd31, s & ~33'd31);
               s = (s | 33'd31) + 33'd1;
            end
            if (s < e && e[4:0] != 0) begin
               push(2'd0, e & ~33'd31, e & ~33'd31);
               e = e & ~33'd31;
            end
            push_chunks(s, e, 1'b0, 1'b1);
         end
         2'd1: push_chunks(s & ~33'd31, (e + 33'd31) & ~33'd31, !wt, 1'b0);
         2'd2: push_chunks(s & ~33'd31, (e + 33'd31) & ~33'd31, !wt, 1'b1);
         default: ;
      endcase
   endtask

   // monitor: drives ready, pops and compares accepted commands
   always @(negedge clk) begin
      item_t got, exp;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cmd_ready = rdy_always ? 1'b1 : (lfsr[0] | lfsr[3]);
      if (rst_n) begin
         got.kind = cmd_kind; got.lo = cmd_lo; got.hi = cmd_hi;
         if (cmd_valid && req_ready)
            check(1'b0, "R1", "command while idle", 98'(req_ready), 98'(0));
         if (prev_wait)
            check(cmd_valid && got == prev_item, "R10", "held command",
                  {cmd_valid, got}, {1'b1, prev_item});
         if (cmd_valid && cmd_ready) begin
            if (exp_q.size() == 0)
               check(1'b0, cur_tag, "unexpected command", 98'(got), 98'(0));
            else begin
               exp = exp_q.pop_front();
               check(got == exp, cur_tag, "command", 98'(got), 98'(exp));
            end
         end
         if (done) begin
            done_seen++;
            if (exp_q.size() != 0)
               check(1'b0, "R11", "done before last command", 98'(exp_q.size()), 98'(0));
            if (prev_done)
               check(1'b0, "R11", "done longer than one cycle", 98'(2), 98'(1));
         end
         prev_done = done;
         prev_wait = cmd_valid && !cmd_ready;
         prev_item = got;
      end
   end

   task automatic run_req(input string tag, input logic [1:0] op, input logic [31:0] s,
                          input logic [31:0] e, input bit wt, input bit poke);
      cur_tag = tag;
      build(op, s, e, wt);
      done_seen = 0;
      @(negedge clk);
      req_valid = 1'b1; req_op = op; req_start = s; req_end = e; req_wt_override = wt;
      @(negedge clk);
      req_valid = 1'b0; req_wt_override = 1'b0;
      check(req_ready == 1'b0, "R1", "busy after accept", 98'(req_ready), 98'(0));
      if (poke) begin
         @(negedge clk);
         req_valid = 1'b1; req_op = 2'd0; req_start = 32'hA000; req_end = 32'hA400;
         @(negedge clk);
         req_valid = 1'b0;
      end
      while (done_seen == 0) @(negedge clk);
      @(negedge clk);
      check(exp_q.size() == 0 && done_seen == 1, "R11", "stream complete at done",
            {66'(exp_q.size()), 32'(done_seen)}, {66'(0), 32'(1)});
      check(req_ready == 1'b1 && !cmd_valid, tag, "idle after done",
            {req_ready, cmd_valid}, {1'b1, 1'b0});
      exp_q.delete();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      check(1'b0, "R1", "watchdog expired", 98'(0), 98'(1));
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(req_ready && !cmd_valid && !done, "R1", "reset state",
            {req_ready, cmd_valid, done}, {1'b1, 1'b0, 1'b0});

      run_req("R2", 2'd0, 32'h0000_1000, 32'h0000_1400, 1'b0, 1'b0);
      run_req("R5", 2'd0, 32'h0000_2005, 32'h0000_2107, 1'b0, 1'b0);
      run_req("R6", 2'd0, 32'h0000_3004, 32'h0000_3010, 1'b0, 1'b0);
      run_req("R6", 2'd0, 32'h0000_3FF0, 32'h0000_4028, 1'b0, 1'b0);
      rdy_always = 1'b0;
      run_req("R4", 2'd1, 32'h0000_0F00, 32'h0000_1800, 1'b0, 1'b0);
      run_req("R7", 2'd1, 32'h0000_7011, 32'h0000_704F, 1'b0, 1'b0);
      run_req("R9", 2'd1, 32'h0000_0F00, 32'h0000_1800, 1'b1, 1'b0);
      run_req("R8", 2'd2, 32'h0000_5FE1, 32'h0000_6900, 1'b0, 1'b0);
      run_req("R9", 2'd2, 32'h0000_5FE1, 32'h0000_6900, 1'b1, 1'b0);
      run_req("R12", 2'd0, 32'h0000_0100, 32'h0000_0100, 1'b0, 1'b0);
      run_req("R12", 2'd3, 32'h0000_0000, 32'h0000_2000, 1'b0, 1'b0);
      run_req("R1", 2'd2, 32'h0000_8000, 32'h0000_9000, 1'b0, 1'b1);
      run_req("R3", 2'd0, 32'h0000_0000, 32'h0000_3000, 1'b0, 1'b0);
      rdy_always = 1'b1;
      run_req("R10", 2'd2, 32'h0001_0C40, 32'h0001_1100, 1'b0, 1'b0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule